// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Array

This block is a small pool of waiting slots placed in front of one execution port. Instructions arrive one per cycle, in program order, each carrying an opcode, the tag its result will be broadcast under, and two source operands. Each operand arrives in one of two forms. It can be a finished value. It can also be the tag of the instruction that will produce the value. A slot that still waits on a tag watches the single result broadcast bus. When that bus carries the awaited tag, the slot copies the broadcast value into the operand.

Any slot whose operands are both present may be sent to the port. When several slots can go, the one dispatched earliest goes first. The port takes at most one instruction per cycle. A unit running a multi-cycle operation raises a busy input, which keeps any further instruction from being sent until the busy input drops. A slot that has been sent becomes free again. A flush input empties the whole pool.

Top module: `rsv_array`

## Requirements
- R1: Out of reset no slot is occupied, `dsp_full` is low and `iss_valid` is low. `dsp_full` is high exactly when all `ENTRIES` slots are occupied. A dispatch presented while `dsp_full` is high is discarded and never reaches the issue outputs.
- R2: An operand dispatched with its ready flag set keeps the dispatched value and needs no broadcast. An entry dispatched in cycle N with both operands ready can issue no earlier than cycle N+1.
- R3: A broadcast in cycle N whose tag equals a waiting operand's tag stores the broadcast data in that operand. The entry can then issue in cycle N+1 at the earliest, and never in cycle N.
- R4: A broadcast whose tag matches a waiting operand of the instruction being dispatched in the same cycle is captured at dispatch, so the wakeup is not lost.
- R5: At most one entry issues per cycle. Among the entries whose operands are both ready, the one dispatched earliest issues.
- R6: While `port_busy` is high, `iss_valid` stays low and no entry leaves the pool.
- R7: An issued entry is released at the clock edge that ends its issue cycle. A pool that was full therefore drops `dsp_full` in the following cycle.
- R8: While `flush` is high, nothing issues and any dispatch is discarded. In the next cycle every slot is empty.
- R9: A broadcast whose tag matches no waiting operand changes no entry. An operand that is already ready is never overwritten by a later broadcast.
- R10: When `iss_valid` is high, `iss_op`, `iss_dtag`, `iss_a` and `iss_b` carry the opcode, the destination tag and the two operand values of the selected entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Empties every slot at the next edge |
| dsp_valid | input | 1 | A dispatch is offered this cycle |
| dsp_op | input | OP_W | Opcode of the offered instruction |
| dsp_dtag | input | TAG_W | Tag its result will be broadcast under |
| dsp_a_rdy | input | 1 | First operand holds a value |
| dsp_a_val | input | DATA_W | First operand value |
| dsp_a_tag | input | TAG_W | Producer tag of the first operand when not ready |
| dsp_b_rdy | input | 1 | Second operand holds a value |
| dsp_b_val | input | DATA_W | Second operand value |
| dsp_b_tag | input | TAG_W | Producer tag of the second operand when not ready |
| dsp_full | output | 1 | Every slot is occupied, so a dispatch is discarded |
| res_valid | input | 1 | A result is broadcast this cycle |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_data | input | DATA_W | Broadcast result value |
| port_busy | input | 1 | Execution port is still occupied, so nothing may issue |
| iss_valid | output | 1 | An entry is sent to the port this cycle |
| iss_op | output | OP_W | Opcode of the issued entry |
| iss_dtag | output | TAG_W | Destination tag of the issued entry |
| iss_a | output | DATA_W | First operand value of the issued entry |
| iss_b | output | DATA_W | Second operand value of the issued entry |

## Verification
The hardest case to reach from the ports is an age decision among several ready entries whose slot order differs from their dispatch order. Reaching it takes a slot freed in the middle of the pool and then refilled while older entries still wait. The stimulus does this in several steps. It parks waiting entries, holds `port_busy` high while more entries become ready, and releases a middle entry through a targeted broadcast. A long random phase then mixes dispatches, broadcasts, busy cycles and rare flushes, which keeps the pool at varied fill levels. Throughout, a queue-based model kept in dispatch order predicts the issue outputs and the full flag in every cycle.

// File: rtl/rsv_pkg.sv
// rsv_pkg: default sizing shared by the reservation station array and its bench.
// Assumes: the top module and the bench take their parameter defaults from here.
package rsv_pkg;
    parameter int unsigned RSV_ENTRIES = 4;
    parameter int unsigned RSV_TAG_W   = 4;
    parameter int unsigned RSV_DATA_W  = 16;
    parameter int unsigned RSV_OP_W    = 4;
endpackage

// File: rtl/rsv_operand.sv
// rsv_operand: one source operand of a slot. It holds either a value or a
// producer tag, and it snoops the result bus to turn the tag into a value.
// Assumes: each producer tag is broadcast once while its consumers wait.
module rsv_operand #(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_rdy,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              rdy,
    output logic [DATA_W-1:0] val
);
    logic [TAG_W-1:0] tag_q;
    logic             hit_now;
    logic             hit_load;

    // Match of the bus against the stored tag and against the arriving tag.
    always_comb begin
        hit_now  = bc_valid && !rdy && (bc_tag == tag_q);
        hit_load = bc_valid && (bc_tag == ld_tag);
    end

    // Operand storage: load at dispatch, otherwise wake up on a matching broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy   <= 1'b0;
            val   <= '0;
            tag_q <= '0;
        end else if (load) begin
            tag_q <= ld_tag;
            if (ld_rdy) begin
                rdy <= 1'b1;
                val <= ld_val;
            end else if (hit_load) begin
                rdy <= 1'b1;
                val <= bc_data;
            end else begin
                rdy <= 1'b0;
            end
        end else if (hit_now) begin
            rdy <= 1'b1;
            val <= bc_data;
        end
    end

    // R3: a waiting operand seeing its tag holds the broadcast data next cycle.
    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !rdy && bc_valid && bc_tag == tag_q) |=> (rdy && val == $past(bc_data)));
    // R4: a broadcast met at dispatch time is not lost.
    p_dispatch_snoop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !ld_rdy && bc_valid && bc_tag == ld_tag) |=> (rdy && val == $past(bc_data)));
    // R9: a ready operand keeps its value until the slot is reloaded.
    p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rdy) |=> (rdy && $stable(val)));
endmodule

// File: rtl/rsv_slot.sv
// rsv_slot: one reservation station entry with its occupancy flag, opcode,
// destination tag and two snooping operands.
// Assumes: alloc only targets a free slot, and release only an occupied one.
module rsv_slot #(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic              release_i,
    input  logic [OP_W-1:0]   d_op,
    input  logic [TAG_W-1:0]  d_dtag,
    input  logic              d_a_rdy,
    input  logic [DATA_W-1:0] d_a_val,
    input  logic [TAG_W-1:0]  d_a_tag,
    input  logic              d_b_rdy,
    input  logic [DATA_W-1:0] d_b_val,
    input  logic [TAG_W-1:0]  d_b_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              occupied,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dtag,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    logic a_rdy;
    logic b_rdy;

    rsv_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opa (
        .clk(clk), .rst_n(rst_n), .load(alloc),
        .ld_rdy(d_a_rdy), .ld_val(d_a_val), .ld_tag(d_a_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rdy(a_rdy), .val(a_val)
    );

    rsv_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opb (
        .clk(clk), .rst_n(rst_n), .load(alloc),
        .ld_rdy(d_b_rdy), .ld_val(d_b_val), .ld_tag(d_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rdy(b_rdy), .val(b_val)
    );

    // Occupancy: set by allocation, cleared by issue or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occupied <= 1'b0;
        end else if (flush) begin
            occupied <= 1'b0;
        end else if (alloc) begin
            occupied <= 1'b1;
        end else if (release_i) begin
            occupied <= 1'b0;
        end
    end

    // Instruction fields captured at dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op   <= '0;
            dtag <= '0;
        end else if (alloc) begin
            op   <= d_op;
            dtag <= d_dtag;
        end
    end

    // Candidate for issue when occupied and both operands hold values.
    always_comb ready = occupied && a_rdy && b_rdy;

    // R1: only a free slot is ever allocated.
    p_alloc_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !occupied);
    // R7: an issued slot is free in the next cycle.
    p_release_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !occupied);
endmodule

// File: rtl/rsv_alloc.sv
// rsv_alloc: picks the lowest-numbered free slot and reports when none is left.
// Assumes: occupancy flags come straight from slot registers.
module rsv_alloc #(
    parameter int unsigned ENTRIES = 4
) (
    input  logic [ENTRIES-1:0] occ,
    output logic [ENTRIES-1:0] free_oh,
    output logic               full
);
    // Priority scan for the first empty slot.
    always_comb begin
        free_oh = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_oh    = '0;
                free_oh[i] = 1'b1;
            end
        end
        full = &occ;
    end

    // R1: the slot offered for allocation is empty and unique.
    always_comb begin
        if ((free_oh & occ) != '0) begin
            assert (1'b0) else $error("p_free_slot_empty_r1");
        end
    end
endmodule

// File: rtl/rsv_picker.sv
// rsv_picker: keeps a pairwise age matrix and grants the oldest ready slot.
// Assumes: alloc_oh is one-hot or zero. Bits of freed slots are stale and are
// rewritten when the slot is allocated again.
module rsv_picker #(
    parameter int unsigned ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [ENTRIES-1:0] ready,
    input  logic [ENTRIES-1:0] alloc_oh,
    output logic [ENTRIES-1:0] grant
);
    // older_q[i][j] set: slot i was dispatched before slot j.
    logic [ENTRIES-1:0] older_q [ENTRIES];

    // Age update: a new slot is younger than every other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) older_q[i] <= '0;
        end else begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (alloc_oh[k]) begin
                    for (int j = 0; j < ENTRIES; j++) begin
                        if (j != k) begin
                            older_q[k][j] <= 1'b0;
                            older_q[j][k] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Grant the ready slot that is older than every other ready slot.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            grant[i] = enable && ready[i];
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && ready[j] && !older_q[i][j]) grant[i] = 1'b0;
            end
        end
    end

    // R5: at most one winner, and only a ready one.
    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~ready) == '0));
    // R5: any ready slot yields a winner when issue is enabled.
    p_no_lost_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ready != '0) |-> (grant != '0));
endmodule

// File: rtl/rsv_array.sv
// rsv_array: reservation station pool for one execution port. In-order
// dispatch into free slots, wakeup by result-bus snooping, oldest-ready issue.
// Assumes: destination tags are unique among in-flight instructions, and the
// unit holds port_busy high for the extra cycles of multi-cycle operations.
module rsv_array
    import rsv_pkg::*;
#(
    parameter int unsigned ENTRIES = RSV_ENTRIES,
    parameter int unsigned TAG_W   = RSV_TAG_W,
    parameter int unsigned DATA_W  = RSV_DATA_W,
    parameter int unsigned OP_W    = RSV_OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              dsp_valid,
    input  logic [OP_W-1:0]   dsp_op,
    input  logic [TAG_W-1:0]  dsp_dtag,
    input  logic              dsp_a_rdy,
    input  logic [DATA_W-1:0] dsp_a_val,
    input  logic [TAG_W-1:0]  dsp_a_tag,
    input  logic              dsp_b_rdy,
    input  logic [DATA_W-1:0] dsp_b_val,
    input  logic [TAG_W-1:0]  dsp_b_tag,
    output logic              dsp_full,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              port_busy,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dtag,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b
);
    logic [ENTRIES-1:0] occ;
    logic [ENTRIES-1:0] rdy;
    logic [ENTRIES-1:0] free_oh;
    logic [ENTRIES-1:0] alloc_oh;
    logic [ENTRIES-1:0] grant;
    logic               accept;
    logic               issue_en;
    logic [OP_W-1:0]    s_op   [ENTRIES];
    logic [TAG_W-1:0]   s_dtag [ENTRIES];
    logic [DATA_W-1:0]  s_a    [ENTRIES];
    logic [DATA_W-1:0]  s_b    [ENTRIES];

    // Dispatch acceptance and the issue enable.
    always_comb begin
        accept   = dsp_valid && !dsp_full && !flush;
        alloc_oh = accept ? free_oh : '0;
        issue_en = !port_busy && !flush;
    end

    rsv_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .occ(occ), .free_oh(free_oh), .full(dsp_full)
    );

    rsv_picker #(.ENTRIES(ENTRIES)) u_pick (
        .clk(clk), .rst_n(rst_n), .enable(issue_en),
        .ready(rdy), .alloc_oh(alloc_oh), .grant(grant)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        rsv_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .alloc(alloc_oh[g]), .release_i(grant[g]),
            .d_op(dsp_op), .d_dtag(dsp_dtag),
            .d_a_rdy(dsp_a_rdy), .d_a_val(dsp_a_val), .d_a_tag(dsp_a_tag),
            .d_b_rdy(dsp_b_rdy), .d_b_val(dsp_b_val), .d_b_tag(dsp_b_tag),
            .bc_valid(res_valid), .bc_tag(res_tag), .bc_data(res_data),
            .occupied(occ[g]), .ready(rdy[g]),
            .op(s_op[g]), .dtag(s_dtag[g]), .a_val(s_a[g]), .b_val(s_b[g])
        );
    end

    // Issue mux: OR together the fields of the granted slot.
    always_comb begin
        iss_valid = |grant;
        iss_op    = '0;
        iss_dtag  = '0;
        iss_a     = '0;
        iss_b     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant[i]) begin
                iss_op   = iss_op   | s_op[i];
                iss_dtag = iss_dtag | s_dtag[i];
                iss_a    = iss_a    | s_a[i];
                iss_b    = iss_b    | s_b[i];
            end
        end
    end

    // R6: a busy port never receives an instruction.
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_busy |-> !iss_valid);
    // R8: a flush empties the pool by the next cycle.
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!dsp_full && !iss_valid));
    // R8: nothing issues during a flush.
    p_flush_no_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_valid);
    // R1: a full pool stays full unless something issues or a flush occurs.
    p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_full && !iss_valid && !flush) |=> dsp_full);
endmodule

// File: tb/rsv_array_test.sv
// rsv_array_test: behavioural queue model kept in dispatch order, compared
// against the issue outputs and the full flag every cycle.
module rsv_array_test;
    localparam int N  = 4;
    localparam int TW = 4;
    localparam int DW = 16;
    localparam int OW = 4;

    typedef struct {
        logic [OW-1:0] op;
        logic [TW-1:0] dtag;
        bit            ar;
        logic [DW-1:0] av;
        logic [TW-1:0] at;
        bit            br;
        logic [DW-1:0] bv;
        logic [TW-1:0] bt;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic dsp_valid = 1'b0;
    logic [OW-1:0] dsp_op = '0;
    logic [TW-1:0] dsp_dtag = '0;
    logic dsp_a_rdy = 1'b0;
    logic [DW-1:0] dsp_a_val = '0;
    logic [TW-1:0] dsp_a_tag = '0;
    logic dsp_b_rdy = 1'b0;
    logic [DW-1:0] dsp_b_val = '0;
    logic [TW-1:0] dsp_b_tag = '0;
    logic dsp_full;
    logic res_valid = 1'b0;
    logic [TW-1:0] res_tag = '0;
    logic [DW-1:0] res_data = '0;
    logic port_busy = 1'b0;
    logic iss_valid;
    logic [OW-1:0] iss_op;
    logic [TW-1:0] iss_dtag;
    logic [DW-1:0] iss_a;
    logic [DW-1:0] iss_b;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    ent_t q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    rsv_array #(.ENTRIES(N), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_dtag(dsp_dtag),
        .dsp_a_rdy(dsp_a_rdy), .dsp_a_val(dsp_a_val), .dsp_a_tag(dsp_a_tag),
        .dsp_b_rdy(dsp_b_rdy), .dsp_b_val(dsp_b_val), .dsp_b_tag(dsp_b_tag),
        .dsp_full(dsp_full), .res_valid(res_valid), .res_tag(res_tag),
        .res_data(res_data), .port_busy(port_busy), .iss_valid(iss_valid),
        .iss_op(iss_op), .iss_dtag(iss_dtag), .iss_a(iss_a), .iss_b(iss_b)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Index of the oldest entry with both operands present, or -1.
    function automatic int pick_oldest();
        if (port_busy || flush) return -1;
        foreach (q[i]) if (q[i].ar && q[i].br) return i;
        return -1;
    endfunction

    // Apply a broadcast to one model entry.
    function automatic ent_t wake(ent_t e);
        ent_t r = e;
        if (res_valid && !r.ar && r.at == res_tag) begin r.ar = 1; r.av = res_data; end
        if (res_valid && !r.br && r.bt == res_tag) begin r.br = 1; r.bv = res_data; end
        return r;
    endfunction

    // Compare this cycle's outputs with the model, then advance the model.
    task automatic cyc();
        int  w;
        bit  was_full;
        ent_t n;
        #1;
        w = pick_oldest();
        was_full = (q.size() == N);
        chk(dsp_full == was_full, cur_req, "dsp_full", 32'(dsp_full), 32'(was_full));
        chk(iss_valid == (w >= 0), cur_req, "iss_valid", 32'(iss_valid), 32'(w >= 0));
        if (w >= 0 && iss_valid) begin
            chk(iss_op == q[w].op, "R10", "iss_op", 32'(iss_op), 32'(q[w].op));
            chk(iss_dtag == q[w].dtag, "R10", "iss_dtag", 32'(iss_dtag), 32'(q[w].dtag));
            chk(iss_a == q[w].av, cur_req, "iss_a", 32'(iss_a), 32'(q[w].av));
            chk(iss_b == q[w].bv, cur_req, "iss_b", 32'(iss_b), 32'(q[w].bv));
        end
        if (flush) begin
            q.delete();
        end else begin
            if (w >= 0) q.delete(w);
            foreach (q[i]) q[i] = wake(q[i]);
            if (dsp_valid && !was_full) begin
                n.op = dsp_op; n.dtag = dsp_dtag;
                n.ar = dsp_a_rdy; n.av = dsp_a_val; n.at = dsp_a_tag;
                n.br = dsp_b_rdy; n.bv = dsp_b_val; n.bt = dsp_b_tag;
                q.push_back(wake(n));
            end
        end
        @(negedge clk);
    endtask

    task automatic dsp(logic [OW-1:0] op, logic [TW-1:0] dt,
                       bit ar, logic [DW-1:0] av, logic [TW-1:0] at,
                       bit br, logic [DW-1:0] bv, logic [TW-1:0] bt);
        dsp_valid = 1; dsp_op = op; dsp_dtag = dt;
        dsp_a_rdy = ar; dsp_a_val = av; dsp_a_tag = at;
        dsp_b_rdy = br; dsp_b_val = bv; dsp_b_tag = bt;
    endtask

    task automatic bc(logic [TW-1:0] t, logic [DW-1:0] d);
        res_valid = 1; res_tag = t; res_data = d;
    endtask

    task automatic idle();
        dsp_valid = 0; res_valid = 0; port_busy = 0; flush = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state.
        cur_req = "R1";
        cyc();

        // R2: both operands ready at dispatch; issue one cycle later.
        cur_req = "R2";
        dsp(4'h1, 4'h1, 1, 16'h0011, 4'h0, 1, 16'h0022, 4'h0); cyc();
        idle(); cyc(); cyc();

        // R3: wait on tag 5, wake by broadcast.
        cur_req = "R3";
        dsp(4'h2, 4'h2, 0, 16'h0, 4'h5, 1, 16'h000C, 4'h0); cyc();
        idle(); cyc();
        bc(4'h5, 16'h0007); cyc();
        idle(); cyc(); cyc();

        // R9: unrelated broadcast changes nothing; ready operand not overwritten.
        cur_req = "R9";
        dsp(4'h3, 4'h3, 1, 16'h00AA, 4'h6, 0, 16'h0, 4'h7); cyc();
        idle(); bc(4'h6, 16'hDEAD); cyc();
        idle(); bc(4'h8, 16'hBEEF); cyc();
        idle(); cyc();
        bc(4'h7, 16'h0042); cyc();
        idle(); cyc();

        // R4: broadcast arrives in the dispatch cycle.
        cur_req = "R4";
        dsp(4'h4, 4'h4, 0, 16'h0, 4'h9, 0, 16'h0, 4'h9); bc(4'h9, 16'h1234); cyc();
        idle(); cyc(); cyc();

        // R5: ready entries collected under busy, then drained oldest first;
        // a middle slot is freed and refilled so slot order differs from age.
        cur_req = "R5";
        dsp(4'h5, 4'hA, 0, 16'h0, 4'hB, 1, 16'h1, 4'h0); port_busy = 1; cyc();
        dsp(4'h6, 4'hC, 0, 16'h0, 4'hD, 1, 16'h2, 4'h0); port_busy = 1; cyc();
        dsp(4'h7, 4'hE, 0, 16'h0, 4'hF, 1, 16'h3, 4'h0); port_busy = 1; cyc();
        idle(); bc(4'hD, 16'h00D0); cyc();
        idle(); cyc();
        dsp(4'h8, 4'h1, 1, 16'h5, 4'h0, 1, 16'h6, 4'h0); port_busy = 1; cyc();
        idle(); port_busy = 1; bc(4'hF, 16'h00F0); cyc();
        idle(); port_busy = 1; bc(4'hB, 16'h00B0); cyc();
        idle(); cyc(); cyc(); cyc(); cyc();

        // R6: a multi-cycle operation holds the port for two extra cycles.
        cur_req = "R6";
        dsp(4'h9, 4'h2, 1, 16'h9, 4'h0, 1, 16'h9, 4'h0); cyc();
        dsp(4'hA, 4'h3, 1, 16'hA, 4'h0, 1, 16'hA, 4'h0); cyc();
        idle(); port_busy = 1; cyc(); cyc();
        idle(); cyc(); cyc();

        // R1 / R7: fill the pool, discard an extra dispatch, then free a slot.
        cur_req = "R1";
        for (int i = 0; i < 5; i++) begin
            dsp(OW'(i), TW'(i), 0, 16'h0, TW'(8 + i), 1, DW'(i), 4'h0);
            cyc();
        end
        idle(); cyc();
        cur_req = "R7";
        bc(4'h9, 16'h0099); cyc();
        idle(); cyc(); cyc();
        for (int i = 0; i < 5; i++) begin
            bc(TW'(8 + i), DW'(16'h100 + i)); cyc();
        end
        idle(); cyc(); cyc(); cyc(); cyc();

        // R8: flush with pending and ready entries plus a discarded dispatch.
        cur_req = "R8";
        dsp(4'h1, 4'h5, 1, 16'h1, 4'h0, 1, 16'h1, 4'h0); cyc();
        dsp(4'h2, 4'h6, 0, 16'h0, 4'h3, 1, 16'h1, 4'h0); port_busy = 1; cyc();
        dsp(4'h3, 4'h7, 1, 16'h1, 4'h0, 1, 16'h1, 4'h0); flush = 1; cyc();
        idle(); cyc(); bc(4'h3, 16'h3333); cyc(); idle(); cyc();

        // Random mix of all stimuli.
        cur_req = "R5";
        for (int c = 0; c < 3000; c++) begin
            idle();
            if ($urandom_range(0, 99) < 60)
                dsp(OW'($urandom), TW'($urandom), 1'($urandom_range(0, 2) == 0), DW'($urandom),
                    TW'($urandom), 1'($urandom_range(0, 2) == 0), DW'($urandom), TW'($urandom));
            if ($urandom_range(0, 99) < 55) bc(TW'($urandom), DW'($urandom));
            port_busy = ($urandom_range(0, 99) < 20);
            flush = ($urandom_range(0, 99) < 2);
            cyc();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule